// File: doc/BRIEF.md
# Vehicle Anti-Theft Alarm Controller

This block guards a parked vehicle. Once the ignition is off and every door is shut, it counts down an arming delay in whole seconds and then arms itself. If the driver door opens while it is armed, it starts a grace countdown. If the owner has not authenticated when the countdown runs out, it raises the siren. Authentication is a concealed action: brake pedal and hidden switch held together with the ignition on. That action disarms the controller from any guarded state. It also unlocks the fuel pump, which stays locked otherwise, whatever the siren is doing.

Inputs are taken as already debounced. A one-cycle pulse once per second paces every countdown. Both timing lengths sit in registers that can be rewritten at runtime. A new value is used from the next countdown start, and a countdown already running keeps the length it captured when it began. The status lamp is dark when disarmed, lit steadily during the grace countdown, and toggles once per second while armed or alarming.

States: `ST_DISARMED`, `ST_ARMED`, `ST_TRIG` (grace countdown), `ST_ALARM`. Transitions:
- DISARMED→ARMED when the arming countdown ends with the vehicle still parked.
- ARMED→TRIG when the driver door opens.
- TRIG→ALARM when the grace countdown ends.
- ARMED/TRIG/ALARM→DISARMED on authentication.
- Within DISARMED, the arming countdown is cancelled whenever the vehicle stops being parked, and it restarts from the full length.

Top module: `car_guard_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the controller in DISARMED with siren_en, pump_en and status_led all low.
- R2: In DISARMED, once the ignition is off and all door_open bits are 0, the arming length is captured one cycle later. The controller enters ARMED on the clock edge after the tick that brings that count to zero. It then shows status_led high and siren_en low.
- R3: In DISARMED, ignition on or any door open cancels the arming countdown. A new countdown of the full captured length starts only after the vehicle is parked again.
- R4: In ARMED, door_open[0] (the driver door) moves the controller to TRIG on the next edge, and status_led stays high on every tick in TRIG. Doors at other indices have no effect in ARMED.
- R5: In TRIG, the grace countdown ends on its final tick. On the following edge the controller enters ALARM and siren_en goes high. siren_en is never high in any other state.
- R6: Authentication (ignition_on, brake_on and hidden_sw all high in one cycle) from ARMED, TRIG or ALARM returns the controller to DISARMED on the next edge, with siren_en and status_led low.
- R7: pump_en rises on the edge after authentication and stays high while ignition_on stays high. It falls on the edge after ignition_on goes low. Brake or hidden switch alone, or both without ignition, never raise it.
- R8: In ARMED and ALARM, status_led starts high on entry and inverts on each tick. In DISARMED it is low.
- R9: A cycle with cfg_we high loads cfg_arm_secs and cfg_grace_secs, which are used from the next countdown start. A write while a countdown runs does not alter that countdown. Reset values are 6 s (arming) and 8 s (grace).
- R10: Countdowns change only on cycles where tick_1hz is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ignition_on | input | 1 | Ignition switch on |
| door_open | input | N_DOORS | Door-open flags, bit 0 is the driver door |
| brake_on | input | 1 | Brake pedal pressed |
| hidden_sw | input | 1 | Concealed owner switch pressed |
| cfg_we | input | 1 | Load both timing lengths this cycle |
| cfg_arm_secs | input | SEC_W | New arming delay in seconds |
| cfg_grace_secs | input | SEC_W | New grace countdown in seconds |
| siren_en | output | 1 | Siren enable |
| pump_en | output | 1 | Fuel-pump enable |
| status_led | output | 1 | Status lamp |

## Verification
Assertions in the RTL check on every cycle the order of state entry: ALARM is reached only from TRIG, and TRIG only from ARMED with the driver door open. They also check that authentication always lands in DISARMED, that the counter holds still between ticks, and that the pump never unlocks without authentication and drops once the ignition goes off. The exact second at which arming and alarm happen can only be shown by the directed scenarios. The same holds for the cancel-and-restart of the arming delay, the lamp's blink phase, the immunity of passenger doors and the capture of rewritten lengths. In those scenarios the bench counts ticks and samples the outputs on the cycle each change is due.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_TRIG     = 2'd2,
        ST_ALARM    = 2'd3
    } guard_state_t;

    function automatic logic is_blinking(guard_state_t s);
        return (s == ST_ARMED) || (s == ST_ALARM);
    endfunction

endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs #(
    parameter int SEC_W     = 8,
    parameter int DEF_ARM   = 6,
    parameter int DEF_GRACE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEC_W-1:0] arm_in,
    input  logic [SEC_W-1:0] grace_in,
    output logic [SEC_W-1:0] arm_len,
    output logic [SEC_W-1:0] grace_len
);

    localparam logic [SEC_W-1:0] ARM_RST   = SEC_W'(DEF_ARM);
    localparam logic [SEC_W-1:0] GRACE_RST = SEC_W'(DEF_GRACE);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_len   <= ARM_RST;
            grace_len <= GRACE_RST;
        end else if (we) begin
            arm_len   <= arm_in;
            grace_len <= grace_in;
        end
    end

    // R9: a write lands on the next edge with exactly the offered values
    a_r9_cfg_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (arm_len == $past(arm_in)) && (grace_len == $past(grace_in)));

endmodule

// File: rtl/guard_countdown.sv
module guard_countdown #(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             clear,
    input  logic [SEC_W-1:0] load_val,
    output logic             running,
    output logic             done
);

    localparam logic [SEC_W-1:0] ZERO = '0;

    logic [SEC_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= ZERO;
            running  <= 1'b0;
        end else if (clear) begin
            remain_q <= ZERO;
            running  <= 1'b0;
        end else if (load) begin
            remain_q <= load_val;
            running  <= 1'b1;
        end else if (running && tick && (remain_q != ZERO)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = running && (remain_q == ZERO);

    // R10: without a tick a running count does not move
    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (running && !tick && !load && !clear) |=> (remain_q == $past(remain_q)));

    // R10: a tick removes at most one second, never wrapping
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (running && !load && !clear) |=> (remain_q <= $past(remain_q)));

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import guard_pkg::*;
#(
    parameter int N_DOORS = 4,
    parameter int DRV_IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ignition_on,
    input  logic [N_DOORS-1:0] door_open,
    input  logic               auth,
    input  logic               cnt_running,
    input  logic               cnt_done,
    output logic               cnt_load,
    output logic               cnt_clear,
    output logic               sel_grace,
    output guard_state_t       state
);

    guard_state_t state_d;
    logic         parked;
    logic         drv_door;

    assign parked   = !ignition_on && (door_open == '0);
    assign drv_door = door_open[DRV_IDX];

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DISARMED;
        else     state <= state_d;
    end

    always_comb begin
        state_d   = state;
        cnt_load  = 1'b0;
        cnt_clear = 1'b0;
        sel_grace = 1'b0;
        unique case (state)
            ST_DISARMED: begin
                if (!parked) begin
                    cnt_clear = 1'b1;
                end else if (cnt_done) begin
                    cnt_clear = 1'b1;
                    state_d   = ST_ARMED;
                end else if (!cnt_running) begin
                    cnt_load  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (auth) begin
                    cnt_clear = 1'b1;
                    state_d   = ST_DISARMED;
                end else if (drv_door) begin
                    cnt_load  = 1'b1;
                    sel_grace = 1'b1;
                    state_d   = ST_TRIG;
                end
            end
            ST_TRIG: begin
                if (auth) begin
                    cnt_clear = 1'b1;
                    state_d   = ST_DISARMED;
                end else if (cnt_done) begin
                    cnt_clear = 1'b1;
                    state_d   = ST_ALARM;
                end
            end
            ST_ALARM: begin
                if (auth) begin
                    cnt_clear = 1'b1;
                    state_d   = ST_DISARMED;
                end
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    // R5: the alarm is entered only out of the grace countdown
    a_r5_alarm_from_trig: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ALARM) ##1 (state == ST_ALARM) |-> $past(state) == ST_TRIG);

    // R4: the grace countdown starts only from ARMED with the driver door open
    a_r4_trig_entry: assert property (@(posedge clk) disable iff (rst)
        (state != ST_TRIG) ##1 (state == ST_TRIG)
            |-> ($past(state) == ST_ARMED) && $past(drv_door));

    // R6: authentication from any guarded state disarms
    a_r6_auth_disarms: assert property (@(posedge clk) disable iff (rst)
        (auth && (state != ST_DISARMED)) |=> (state == ST_DISARMED));

    // R2: arming happens only while parked
    a_r2_arm_when_parked: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISARMED) ##1 (state == ST_ARMED) |-> $past(parked));

endmodule

// File: rtl/guard_outputs.sv
module guard_outputs
    import guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ignition_on,
    input  logic         auth,
    input  guard_state_t state,
    output logic         siren_en,
    output logic         pump_en,
    output logic         status_led
);

    logic blink_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blink_q <= 1'b1;
            pump_en <= 1'b0;
        end else begin
            if (!is_blinking(state)) blink_q <= 1'b1;
            else if (tick)           blink_q <= ~blink_q;
            pump_en <= auth || (pump_en && ignition_on);
        end
    end

    always_comb begin
        siren_en   = 1'b0;
        status_led = 1'b0;
        unique case (state)
            ST_DISARMED: status_led = 1'b0;
            ST_ARMED:    status_led = blink_q;
            ST_TRIG:     status_led = 1'b1;
            ST_ALARM: begin
                status_led = blink_q;
                siren_en   = 1'b1;
            end
            default: status_led = 1'b0;
        endcase
    end

    // R7: the pump unlocks only after authentication
    a_r7_pump_needs_auth: assert property (@(posedge clk) disable iff (rst)
        (!pump_en) ##1 pump_en |-> $past(auth));

    // R7: ignition off relocks the pump on the next edge
    a_r7_pump_relock: assert property (@(posedge clk) disable iff (rst)
        !ignition_on |=> !pump_en);

    // R8: outside a tick the blinking lamp keeps its level
    a_r8_blink_steady: assert property (@(posedge clk) disable iff (rst)
        (is_blinking(state) && !tick) |=> (blink_q == $past(blink_q)));

endmodule

// File: rtl/car_guard_ctrl.sv
module car_guard_ctrl
    import guard_pkg::*;
#(
    parameter int N_DOORS   = 4,
    parameter int SEC_W     = 8,
    parameter int DEF_ARM   = 6,
    parameter int DEF_GRACE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1hz,
    input  logic               ignition_on,
    input  logic [N_DOORS-1:0] door_open,
    input  logic               brake_on,
    input  logic               hidden_sw,
    input  logic               cfg_we,
    input  logic [SEC_W-1:0]   cfg_arm_secs,
    input  logic [SEC_W-1:0]   cfg_grace_secs,
    output logic               siren_en,
    output logic               pump_en,
    output logic               status_led
);

    localparam int DRV_IDX = 0;

    logic             auth;
    logic [SEC_W-1:0] arm_len;
    logic [SEC_W-1:0] grace_len;
    logic             cnt_load;
    logic             cnt_clear;
    logic             cnt_running;
    logic             cnt_done;
    logic             sel_grace;
    guard_state_t     state;

    assign auth = ignition_on && brake_on && hidden_sw;

    guard_cfg_regs #(
        .SEC_W     (SEC_W),
        .DEF_ARM   (DEF_ARM),
        .DEF_GRACE (DEF_GRACE)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .arm_in    (cfg_arm_secs),
        .grace_in  (cfg_grace_secs),
        .arm_len   (arm_len),
        .grace_len (grace_len)
    );

    guard_countdown #(
        .SEC_W (SEC_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load     (cnt_load),
        .clear    (cnt_clear),
        .load_val (sel_grace ? grace_len : arm_len),
        .running  (cnt_running),
        .done     (cnt_done)
    );

    guard_fsm #(
        .N_DOORS (N_DOORS),
        .DRV_IDX (DRV_IDX)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ignition_on (ignition_on),
        .door_open   (door_open),
        .auth        (auth),
        .cnt_running (cnt_running),
        .cnt_done    (cnt_done),
        .cnt_load    (cnt_load),
        .cnt_clear   (cnt_clear),
        .sel_grace   (sel_grace),
        .state       (state)
    );

    guard_outputs u_out (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_1hz),
        .ignition_on (ignition_on),
        .auth        (auth),
        .state       (state),
        .siren_en    (siren_en),
        .pump_en     (pump_en),
        .status_led  (status_led)
    );

endmodule

// File: tb/car_guard_ctrl_bench.sv
module car_guard_ctrl_bench;

    localparam int ND = 4;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_1hz = 1'b0;
    logic          ignition_on = 1'b0;
    logic [ND-1:0] door_open = '0;
    logic          brake_on = 1'b0;
    logic          hidden_sw = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_arm_secs = '0;
    logic [SW-1:0] cfg_grace_secs = '0;
    logic          siren_en, pump_en, status_led;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    car_guard_ctrl #(.N_DOORS(ND), .SEC_W(SW), .DEF_ARM(6), .DEF_GRACE(8)) u_car_guard_ctrl (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .ignition_on(ignition_on),
        .door_open(door_open), .brake_on(brake_on), .hidden_sw(hidden_sw),
        .cfg_we(cfg_we), .cfg_arm_secs(cfg_arm_secs), .cfg_grace_secs(cfg_grace_secs),
        .siren_en(siren_en), .pump_en(pump_en), .status_led(status_led)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            step(1);
            tick_1hz = 1'b1;
            step(1);
            tick_1hz = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ignition_on = 1'b1; door_open = '0;
        brake_on = 1'b0; hidden_sw = 1'b0; cfg_we = 1'b0; tick_1hz = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic arm_now(input int secs);
        ignition_on = 1'b0; door_open = '0;
        step(2);
        pulse_tick(secs);
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 siren", siren_en, 1'b0);
        chk("R1 pump", pump_en, 1'b0);
        chk("R1 led", status_led, 1'b0);
    endtask

    task automatic t_arm();
        do_reset();
        ignition_on = 1'b0;
        step(2);
        pulse_tick(5);
        step(2);
        chk("R2 not armed after 5 ticks", status_led, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R2 armed after 6 ticks", status_led, 1'b1);
        chk("R2 siren low", siren_en, 1'b0);
    endtask

    task automatic t_restart();
        do_reset();
        ignition_on = 1'b0;
        step(2);
        pulse_tick(4);
        door_open = 4'b0100;
        step(2);
        door_open = '0;
        step(2);
        pulse_tick(5);
        step(2);
        chk("R3 door restart not armed", status_led, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R3 door restart armed", status_led, 1'b1);
        do_reset();
        ignition_on = 1'b0;
        step(2);
        pulse_tick(5);
        ignition_on = 1'b1;
        step(2);
        ignition_on = 1'b0;
        step(2);
        pulse_tick(5);
        step(2);
        chk("R3 ignition restart not armed", status_led, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R3 ignition restart armed", status_led, 1'b1);
    endtask

    task automatic t_blink_other_door();
        do_reset();
        arm_now(6);
        chk("R8 armed entry high", status_led, 1'b1);
        door_open = 4'b0010;
        pulse_tick(1);
        chk("R4 passenger door ignored", status_led, 1'b0);
        pulse_tick(1);
        chk("R8 armed blink back high", status_led, 1'b1);
        chk("R4 passenger door no siren", siren_en, 1'b0);
        door_open = '0;
    endtask

    task automatic t_trigger_alarm();
        do_reset();
        arm_now(6);
        pulse_tick(1);
        door_open = 4'b0001;
        step(1);
        chk("R4 trig lamp solid", status_led, 1'b1);
        pulse_tick(7);
        chk("R4 trig lamp still solid", status_led, 1'b1);
        chk("R5 no siren before expiry", siren_en, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R5 siren at expiry", siren_en, 1'b1);
        chk("R8 alarm entry high", status_led, 1'b1);
        pulse_tick(1);
        chk("R8 alarm blink low", status_led, 1'b0);
        chk("R7 pump locked in alarm", pump_en, 1'b0);
        ignition_on = 1'b1; brake_on = 1'b1; hidden_sw = 1'b1;
        step(1);
        chk("R6 siren cleared", siren_en, 1'b0);
        chk("R6 lamp off", status_led, 1'b0);
        chk("R7 pump unlocked", pump_en, 1'b1);
        brake_on = 1'b0; hidden_sw = 1'b0;
        step(3);
        chk("R7 pump held with ignition", pump_en, 1'b1);
        ignition_on = 1'b0;
        step(1);
        chk("R7 pump relocked", pump_en, 1'b0);
    endtask

    task automatic t_auth_armed();
        do_reset();
        arm_now(6);
        ignition_on = 1'b1; brake_on = 1'b1; hidden_sw = 1'b1;
        step(1);
        brake_on = 1'b0; hidden_sw = 1'b0;
        pulse_tick(1);
        chk("R6 disarmed from armed", status_led, 1'b0);
        chk("R6 no siren", siren_en, 1'b0);
    endtask

    task automatic t_pump_negative();
        do_reset();
        ignition_on = 1'b1; brake_on = 1'b1; hidden_sw = 1'b0;
        step(2);
        chk("R7 brake only", pump_en, 1'b0);
        brake_on = 1'b0; hidden_sw = 1'b1;
        step(2);
        chk("R7 hidden only", pump_en, 1'b0);
        ignition_on = 1'b0; brake_on = 1'b1;
        step(2);
        chk("R7 no ignition", pump_en, 1'b0);
        brake_on = 1'b0; hidden_sw = 1'b0;
    endtask

    task automatic t_config();
        do_reset();
        cfg_arm_secs = 8'd3; cfg_grace_secs = 8'd2; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        ignition_on = 1'b0;
        step(2);
        pulse_tick(1);
        cfg_arm_secs = 8'd20; cfg_grace_secs = 8'd2; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        pulse_tick(1);
        step(2);
        chk("R9 not armed after 2 of 3", status_led, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R9 armed with captured 3", status_led, 1'b1);
        door_open = 4'b0001;
        step(1);
        pulse_tick(1);
        cfg_arm_secs = 8'd20; cfg_grace_secs = 8'd9; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        chk("R9 no siren mid grace", siren_en, 1'b0);
        pulse_tick(1);
        step(1);
        chk("R9 siren with captured grace 2", siren_en, 1'b1);
        step(20);
        chk("R10 alarm held without ticks", siren_en, 1'b1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_arm();
        t_restart();
        t_blink_other_door();
        t_trigger_alarm();
        t_auth_armed();
        t_pump_negative();
        t_config();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule